// File: doc/BRIEF.md
# AXI-Lite LED Mode Controller

This peripheral drives a single LED from a processor through a 32-bit AXI4-Lite slave port. It holds four 32-bit registers that software can both write and read back. Three of them each carry one request bit, for steady on, steady off and blinking. The fourth carries a commit bit. Writing a request bit changes nothing by itself. The LED takes on a new behaviour only when software moves the commit bit from 0 to 1.

Blink timing comes from a free-running counter that wraps after a build-time number of clock cycles. In blink mode the LED is lit for the first half of each period and dark for the rest. For a 100 MHz system clock, the intended period range is 10,000,000 cycles (10 Hz) to 100,000,000 cycles (1 Hz), and the default is 100,000,000.

Top module: `led_mode_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all four registers to zero, drives the LED low, selects the off mode, and leaves both response channels idle.
- R2: Each of the four registers, at byte offsets 0x0, 0x4, 0x8 and 0xC, stores the value written to it. A read at that offset returns the stored value.
- R3: Each write strobe bit enables one byte lane (strobe bit n covers data bits 8n+7..8n). Lanes whose strobe is low keep their previous contents.
- R4: The write address and write data may arrive in either order or in the same cycle. The write response is raised only after both have been accepted, and both the write and read responses are always OKAY (2'b00).
- R5: Writing any register without a 0-to-1 change of the commit bit leaves the LED behaviour unchanged.
- R6: A rising edge of the commit bit (bit 24 at offset 0xC) with the on request (bit 0 at offset 0x0) set turns the LED steadily on.
- R7: A commit with the off request (bit 8 at offset 0x4) as the highest set request turns the LED steadily off.
- R8: A commit with the blink request (bit 16 at offset 0x8) as the only set request makes the LED blink. Each period of BLINK_PERIOD cycles has BLINK_PERIOD/2 cycles high (rounded down) followed by the remaining cycles low.
- R9: When several requests are set at the commit, on wins over off and off wins over blink. A commit with no request set keeps the current mode.
- R10: A write that leaves the commit bit at 1 is not a new commit and does not change the mode.
- R11: A raised write or read response stays raised, with its data unchanged, until the master accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| led_o | output | 1 | LED drive, registered |

## Verification
The hardest case to reach is a write that sets the commit register while its bit is already 1. Such a write looks like a commit at the bus, but it must be ignored. The stimulus first commits the on mode and then leaves the commit bit high. It switches the requests to off and rewrites the commit register with bit 24 still set, and the LED must stay lit until software clears the bit and sets it again. Priority between requests is also tested by leaving lower-priority request bits set from earlier data patterns. Blink timing is measured as run lengths of high and low LED cycles, so the result does not depend on where the free-running counter happened to be.

// File: rtl/led_ctrl_pkg.sv
package led_ctrl_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_ON    = 2'd1,
    MODE_BLINK = 2'd2
  } led_mode_e;

  // Register slots: software decodes these offsets and bit positions
  localparam int REG_ON     = 0;
  localparam int REG_OFF    = 1;
  localparam int REG_BLINK  = 2;
  localparam int REG_COMMIT = 3;

  localparam int BIT_ON     = 0;
  localparam int BIT_OFF    = 8;
  localparam int BIT_BLINK  = 16;
  localparam int BIT_COMMIT = 24;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/led_axil_regs.sv
module led_axil_regs #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          awaddr,
  input  logic                       awvalid,
  output logic                       awready,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [DATA_W/8-1:0]        wstrb,
  input  logic                       wvalid,
  output logic                       wready,
  output logic [1:0]                 bresp,
  output logic                       bvalid,
  input  logic                       bready,
  input  logic [ADDR_W-1:0]          araddr,
  input  logic                       arvalid,
  output logic                       arready,
  output logic [DATA_W-1:0]          rdata,
  output logic [1:0]                 rresp,
  output logic                       rvalid,
  input  logic                       rready,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  localparam int STRB_W   = DATA_W / 8;
  localparam int ADDR_LSB = $clog2(STRB_W);
  localparam int IDX_W    = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic              aw_full, w_full;
  logic [IDX_W-1:0]  aw_idx;
  logic [DATA_W-1:0] w_data_q;
  logic [STRB_W-1:0] w_strb_q;
  logic              do_write;
  logic [IDX_W-1:0]  ar_idx;
  logic              unused_addr_bits;

  assign do_write = aw_full & w_full & ~bvalid;
  assign awready  = ~aw_full;
  assign wready   = ~w_full;
  assign arready  = ~rvalid;
  assign bresp    = led_ctrl_pkg::RESP_OKAY;
  assign rresp    = led_ctrl_pkg::RESP_OKAY;
  assign ar_idx   = araddr[ADDR_LSB +: IDX_W];
  assign unused_addr_bits = ^{awaddr[ADDR_LSB-1:0], araddr[ADDR_LSB-1:0],
                              awaddr[ADDR_W-1:ADDR_LSB+IDX_W], araddr[ADDR_W-1:ADDR_LSB+IDX_W]};

  // Address and data are captured independently; the write fires once both are held
  always_ff @(posedge clk) begin
    if (rst) begin
      aw_full  <= 1'b0;
      aw_idx   <= '0;
    end else if (awvalid && awready) begin
      aw_full  <= 1'b1;
      aw_idx   <= awaddr[ADDR_LSB +: IDX_W];
    end else if (do_write) begin
      aw_full  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      w_full   <= 1'b0;
      w_data_q <= '0;
      w_strb_q <= '0;
    end else if (wvalid && wready) begin
      w_full   <= 1'b1;
      w_data_q <= wdata;
      w_strb_q <= wstrb;
    end else if (do_write) begin
      w_full   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bvalid <= 1'b0;
    end else if (do_write) begin
      bvalid <= 1'b1;
    end else if (bvalid && bready) begin
      bvalid <= 1'b0;
    end
  end

  // Register file with per-lane enables
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= '0;
    end else if (do_write) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        for (int b = 0; b < STRB_W; b++) begin
          if (aw_idx == IDX_W'(r) && w_strb_q[b])
            regs_q[r][b*8 +: 8] <= w_data_q[b*8 +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (arvalid && arready) begin
      rvalid <= 1'b1;
      rdata  <= regs_q[ar_idx];
    end else if (rvalid && rready) begin
      rvalid <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
  end

endmodule

// File: rtl/led_mode_latch.sv
module led_mode_latch (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    on_req,
  input  logic                    off_req,
  input  logic                    blink_req,
  input  logic                    commit_lvl,
  output led_ctrl_pkg::led_mode_e mode_q
);
  import led_ctrl_pkg::*;

  logic commit_d;
  logic commit_rise;

  assign commit_rise = commit_lvl & ~commit_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_d <= 1'b0;
      mode_q   <= MODE_OFF;
    end else begin
      commit_d <= commit_lvl;
      if (commit_rise) begin
        if (on_req)         mode_q <= MODE_ON;
        else if (off_req)   mode_q <= MODE_OFF;
        else if (blink_req) mode_q <= MODE_BLINK;
      end
    end
  end

endmodule

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
  parameter int BLINK_PERIOD = 100_000_000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  led_ctrl_pkg::led_mode_e mode,
  output logic                    led_o
);
  import led_ctrl_pkg::*;

  localparam int CNT_W = (BLINK_PERIOD > 1) ? $clog2(BLINK_PERIOD) : 1;
  localparam int HALF  = BLINK_PERIOD / 2;

  logic [CNT_W-1:0] cnt_q;
  logic             lit_phase;

  assign lit_phase = (cnt_q < CNT_W'(HALF));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_W'(BLINK_PERIOD - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      led_o <= 1'b0;
    end else begin
      led_o <= (mode == MODE_ON) | ((mode == MODE_BLINK) & lit_phase);
    end
  end

endmodule

// File: rtl/led_mode_ctrl.sv
module led_mode_ctrl #(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 4,
  parameter int BLINK_PERIOD = 100_000_000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  output logic                led_o
);
  import led_ctrl_pkg::*;

  localparam int NUM_REGS = 4;

  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  logic                       on_req, off_req, blink_req, commit_lvl;
  led_mode_e                  mode_q;
  logic                       unused_reg_bits;

  led_axil_regs #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .awaddr   (s_awaddr),
    .awvalid  (s_awvalid),
    .awready  (s_awready),
    .wdata    (s_wdata),
    .wstrb    (s_wstrb),
    .wvalid   (s_wvalid),
    .wready   (s_wready),
    .bresp    (s_bresp),
    .bvalid   (s_bvalid),
    .bready   (s_bready),
    .araddr   (s_araddr),
    .arvalid  (s_arvalid),
    .arready  (s_arready),
    .rdata    (s_rdata),
    .rresp    (s_rresp),
    .rvalid   (s_rvalid),
    .rready   (s_rready),
    .regs_flat(regs_flat)
  );

  assign on_req     = regs_flat[REG_ON*DATA_W + BIT_ON];
  assign off_req    = regs_flat[REG_OFF*DATA_W + BIT_OFF];
  assign blink_req  = regs_flat[REG_BLINK*DATA_W + BIT_BLINK];
  assign commit_lvl = regs_flat[REG_COMMIT*DATA_W + BIT_COMMIT];
  assign unused_reg_bits = ^regs_flat;

  led_mode_latch u_latch (
    .clk       (clk),
    .rst       (rst),
    .on_req    (on_req),
    .off_req   (off_req),
    .blink_req (blink_req),
    .commit_lvl(commit_lvl),
    .mode_q    (mode_q)
  );

  led_blink_gen #(
    .BLINK_PERIOD(BLINK_PERIOD)
  ) u_blink (
    .clk  (clk),
    .rst  (rst),
    .mode (mode_q),
    .led_o(led_o)
  );

endmodule

// File: rtl/led_mode_ctrl_chk.sv
module led_mode_ctrl_chk (
  input logic                    clk,
  input logic                    rst,
  input logic                    bvalid,
  input logic                    bready,
  input logic [1:0]              bresp,
  input logic                    rvalid,
  input logic                    rready,
  input logic [31:0]             rdata,
  input logic [1:0]              rresp,
  input logic                    led,
  input led_ctrl_pkg::led_mode_e mode,
  input logic                    commit_lvl
);
  import led_ctrl_pkg::*;

  // R1: the cycle after reset the LED is dark
  a_r1_reset_led_off: assert property (@(posedge clk) $past(rst) |-> !led);

  // R11: responses are held until accepted
  a_r11_bvalid_hold: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> bvalid);
  a_r11_rvalid_hold: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));

  // R4: responses are always OKAY
  a_r4_bresp_okay: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> (bresp == RESP_OKAY));
  a_r4_rresp_okay: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> (rresp == RESP_OKAY));

  // R5 / R10: the mode moves only right after a 0-to-1 change of the commit bit
  a_r10_mode_on_commit_edge: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |-> ($past(commit_lvl) && !$past(commit_lvl, 2)));

  // R6: on mode lights the LED on the next cycle
  a_r6_on_lights_led: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ON) |=> led);

  // R7: off mode darkens the LED on the next cycle
  a_r7_off_darkens_led: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |=> !led);

endmodule

bind led_mode_ctrl led_mode_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bvalid    (s_bvalid),
  .bready    (s_bready),
  .bresp     (s_bresp),
  .rvalid    (s_rvalid),
  .rready    (s_rready),
  .rdata     (s_rdata),
  .rresp     (s_rresp),
  .led       (led_o),
  .mode      (mode_q),
  .commit_lvl(commit_lvl)
);

// File: tb/led_mode_ctrl_tb.sv
module led_mode_ctrl_tb;
  localparam int PERIOD = 25;
  localparam int HI_N   = PERIOD / 2;
  localparam int LO_N   = PERIOD - PERIOD / 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  s_awaddr = '0;
  logic        s_awvalid = 1'b0;
  logic        s_awready;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_wvalid = 1'b0;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready = 1'b1;
  logic [3:0]  s_araddr = '0;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready = 1'b1;
  logic        led_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q[$];

  always #2 clk = ~clk;

  led_mode_ctrl #(.DATA_W(32), .ADDR_W(4), .BLINK_PERIOD(PERIOD)) u_dut (
    .clk(clk), .rst(rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .led_o(led_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: pops an expected read item at each accepted read beat
  always @(negedge clk) begin
    if (!rst && s_rvalid && s_rready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected read beat", s_rdata, 32'h0);
      end else begin
        rd_item_t it;
        it = exp_q.pop_front();
        chk(s_rdata === it.exp && s_rresp == 2'b00, it.tag, s_rdata, it.exp);
      end
    end
  end

  task automatic send_phase(input bit do_aw, input bit do_w);
    bit acc_aw, acc_w;
    if (do_aw) s_awvalid = 1'b1;
    if (do_w)  s_wvalid  = 1'b1;
    while (s_awvalid || s_wvalid) begin
      acc_aw = s_awvalid && s_awready;
      acc_w  = s_wvalid && s_wready;
      @(negedge clk);
      if (acc_aw) s_awvalid = 1'b0;
      if (acc_w)  s_wvalid  = 1'b0;
    end
  endtask

  // order: 0 both together, 1 address first, 2 data first
  task automatic axi_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s, input int order);
    s_awaddr = a; s_wdata = d; s_wstrb = s;
    if (order == 0) begin
      send_phase(1'b1, 1'b1);
    end else begin
      send_phase(order == 1, order == 2);
      repeat (3) @(negedge clk);
      chk(!s_bvalid, "R4 response before both channels", {31'h0, s_bvalid}, 32'h0);
      send_phase(order == 2, order == 1);
    end
    while (!s_bvalid) @(negedge clk);
    chk(s_bresp == 2'b00, "R4 write response OKAY", {30'h0, s_bresp}, 32'h0);
    @(negedge clk);
  endtask

  task automatic axi_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    s_araddr = a;
    s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic led_hold(input logic expv, input int n, input string tag);
    bit bad = 0;
    logic seen = expv;
    for (int i = 0; i < n; i++) begin
      if (led_o !== expv) begin bad = 1; seen = led_o; end
      @(negedge clk);
    end
    chk(!bad, tag, {31'h0, seen}, {31'h0, expv});
  endtask

  task automatic commit();
    axi_write(4'hC, 32'h0000_0000, 4'hF, 0);
    axi_write(4'hC, 32'h0100_0000, 4'hF, 0);
    repeat (5) @(negedge clk);
  endtask

  task automatic measure_blink(input string tag);
    int hi = 0, lo = 0, guard = 0;
    while (led_o !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
    while (led_o !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    while (led_o === 1'b1 && hi < 200) begin @(negedge clk); hi++; end
    while (led_o === 1'b0 && lo < 200) begin @(negedge clk); lo++; end
    chk(hi == HI_N, {tag, " high run"}, hi, HI_N);
    chk(lo == LO_N, {tag, " low run"}, lo, LO_N);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!led_o && !s_bvalid && !s_rvalid, "R1 reset outputs idle",
        {29'h0, led_o, s_bvalid, s_rvalid}, 32'h0);
    for (int r = 0; r < 4; r++) axi_read(4'(r*4), 32'h0, "R1 register cleared");

    // R2/R4: round trip under three channel orderings
    axi_write(4'h0, 32'hA5A5_5A5A, 4'hF, 0);
    axi_write(4'h4, 32'h1234_5678, 4'hF, 1);
    axi_write(4'h8, 32'hDEAD_BEEF, 4'hF, 2);
    axi_read(4'h0, 32'hA5A5_5A5A, "R2 readback 0x0");
    axi_read(4'h4, 32'h1234_5678, "R2 readback 0x4");
    axi_read(4'h8, 32'hDEAD_BEEF, "R2 readback 0x8");

    // R3: byte lanes; commit lane untouched
    axi_write(4'hC, 32'hFFFF_FFFF, 4'b0101, 0);
    axi_read(4'hC, 32'h00FF_00FF, "R3 strobe lanes 0 and 2");
    axi_write(4'h0, 32'hFFFF_FF01, 4'b0001, 2);
    axi_read(4'h0, 32'hA5A5_5A01, "R3 strobe lane 0 only");
    // R5: requests set (on, blink) but no commit edge
    led_hold(1'b0, 20, "R5 no commit keeps LED off");

    // R6/R9: on wins over pending blink request
    axi_write(4'hC, 32'h0100_0000, 4'hF, 0);
    repeat (5) @(negedge clk);
    led_hold(1'b1, 40, "R6 on mode steady high, R9 on beats blink");

    // R10: commit stays 1, requests switch to off; no change
    axi_write(4'h0, 32'h0, 4'hF, 0);
    axi_write(4'h4, 32'h0000_0100, 4'hF, 0);
    axi_write(4'hC, 32'h0100_0000, 4'hF, 1);
    repeat (5) @(negedge clk);
    led_hold(1'b1, 30, "R10 held commit bit ignored");

    // R7/R9: real edge, off beats blink
    commit();
    led_hold(1'b0, 40, "R7 off mode steady low, R9 off beats blink");

    // R8: blink alone
    axi_write(4'h4, 32'h0, 4'hF, 0);
    commit();
    measure_blink("R8 blink");
    measure_blink("R8 blink second period");

    // R9: commit with no request keeps blink
    axi_write(4'h8, 32'h0, 4'hF, 0);
    commit();
    measure_blink("R9 empty commit keeps blink");

    // R11: stalled read response
    s_rready = 1'b0;
    begin
      rd_item_t it;
      it.exp = 32'h0100_0000; it.tag = "R11 stalled read data";
      exp_q.push_back(it);
    end
    s_araddr = 4'hC; s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 1'b0;
    repeat (4) @(negedge clk);
    chk(s_rvalid && s_rdata == 32'h0100_0000, "R11 read held while stalled", s_rdata, 32'h0100_0000);
    s_rready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);

    // R11: stalled write response
    s_bready = 1'b0;
    s_awaddr = 4'h4; s_wdata = 32'h0BAD_CAFE; s_wstrb = 4'hF;
    send_phase(1'b1, 1'b1);
    while (!s_bvalid) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(s_bvalid, "R11 write response held while stalled", {31'h0, s_bvalid}, 32'h1);
    s_bready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!s_bvalid, "R11 write response released", {31'h0, s_bvalid}, 32'h0);
    axi_read(4'h4, 32'h0BAD_CAFE, "R2 readback after stalled write");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule